// File: doc/BRIEF.md
# PRBS-7 Link Test Pattern Generator and Checker

This block tests a serial link on its parallel side. The transmit half either passes user words through or replaces them with a PRBS-7 stream, one W-bit word per clock. The receive half locks onto an incoming PRBS-7 stream without any handshake. It flags each word that departs from the sequence and counts those words in a saturating counter. A request pulse can spoil one transmitted word on purpose, which lets a far-end checker prove that it catches errors.

For jitter-tolerance testing with an external tester, an error-loopback control sends every receive-side error back out on the transmit stream, one flipped bit per detected error. A polarity control inverts every transmitted bit. This corrects for a differential pair that was swapped on the board. Serialization and bit-error-rate arithmetic belong to the surrounding logic.

Top module: `prbs_link_test`

## Requirements
- R1: While `rst_n` is low, `tx_data`, `rx_err`, `rx_locked` and `rx_err_cnt` are all zero. After release, the block first reacts to its inputs at the third rising clock edge.
- R2: With `pat_tx_sel` = 3'b001, each edge registers the next W bits of the x^7+x^6+1 sequence on `tx_data`. Bit W-1 is the oldest bit. Each new bit is the XOR of the bits 7 and 6 positions earlier. The generator state after a word equals that word's bits [6:0], and the state after reset is 7'h7F.
- R3: With `pat_tx_sel` other than 3'b001 (3'b000 is the off code), the generator holds its state and `tx_data` takes `tx_user` one edge later.
- R4: With `tx_invert` high, every bit of the registered transmit word is inverted, in both passthrough and pattern modes.
- R5: Each rising transition of `tx_force_err` inverts bit 0 of exactly one pattern word. Holding the input high adds no further errors.
- R6: When not locked, the checker predicts each word from bits [6:0] of the previous received word. `rx_locked` rises one edge after the 8th consecutive correct prediction.
- R7: While locked, the checker runs its own sequence. A mismatching word sets `rx_err` for the following cycle only, so one corrupted word gives one error. `rx_err` is never high while `rx_locked` is low.
- R8: `rx_err_cnt` increments by one for each error word and holds at 16'hFFFF.
- R9: Any change of `pat_rx_sel` clears `rx_err_cnt`, `rx_locked` and `rx_err` at that edge.
- R10: With `err_loop_en` high and the pattern enabled, bit 0 of the transmit word is inverted exactly when `rx_err` is high at the edge, and `tx_force_err` has no effect.
- R11: With `pat_rx_sel` other than 3'b001, the checker is idle, with `rx_err` and `rx_locked` low, whatever arrives on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pat_tx_sel | input | 3 | Transmit pattern code, 3'b001 = PRBS-7 |
| tx_force_err | input | 1 | Rising edge spoils one pattern word |
| tx_invert | input | 1 | Invert every transmit bit |
| tx_user | input | W | User data for passthrough mode |
| tx_data | output | W | Registered transmit word |
| pat_rx_sel | input | 3 | Receive pattern code, 3'b001 = PRBS-7 |
| rx_data | input | W | Received parallel word |
| err_loop_en | input | 1 | Send receive errors back through the transmitter |
| rx_err | output | 1 | Error seen in the previous received word |
| rx_locked | output | 1 | Checker is aligned to the sequence |
| rx_err_cnt | output | 16 | Saturating error-word count |

## Verification
The transmitter is driven with random user words in both polarities to separate passthrough from inversion. It is then run in pattern mode, where a wrong tap, bit order or seed shows up on the first word. The receiver gets a clean stream from an unrelated seed, which shows self-alignment and the lock threshold. Single-word bit flips, spaced apart, separate a checker that counts once per corrupted word from one that reseeds from bad data and counts twice. A long run of spoiled words reaches counter saturation. Select changes, and a held force-error level combined with loopback, show which error source drives transmit bit 0.

// File: rtl/prbs_link_pkg.sv
package prbs_link_pkg;
  typedef enum logic [2:0] {
    PAT_OFF   = 3'b000,
    PAT_PRBS7 = 3'b001
  } pat_sel_e;

  localparam int          LFSR_LEN  = 7;
  localparam logic [6:0]  LFSR_SEED = 7'h7F;
endpackage

// File: rtl/prbs7_expand.sv
module prbs7_expand #(
  parameter int W = 16
) (
  input  logic [6:0]   seed_i,
  output logic [W-1:0] word_o
);
  always_comb begin : unroll
    logic [6:0] st;
    logic       nb;
    st     = seed_i;
    word_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      nb        = st[6] ^ st[5];
      word_o[i] = nb;
      st        = {st[5:0], nb};
    end
  end
endmodule

// File: rtl/prbs7_tx_gen.sv
module prbs7_tx_gen
  import prbs_link_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   sel_i,
  input  logic         force_err_i,
  input  logic         loop_en_i,
  input  logic         rx_err_i,
  input  logic         invert_i,
  input  logic [W-1:0] user_i,
  output logic [W-1:0] tx_o
);
  logic [6:0]   state_q;
  logic         force_q;
  logic [W-1:0] tx_q, tx_d, pat_w, raw_w;
  logic         gen_en, inject, flip;

  prbs7_expand #(.W(W)) u_expand (.seed_i(state_q), .word_o(pat_w));

  always_comb begin
    gen_en = (sel_i == PAT_PRBS7);
    inject = force_err_i & ~force_q;
    flip   = loop_en_i ? rx_err_i : inject;
    raw_w  = gen_en ? (pat_w ^ {{(W-1){1'b0}}, flip}) : user_i;
    tx_d   = invert_i ? ~raw_w : raw_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFSR_SEED;
      force_q <= 1'b0;
      tx_q    <= '0;
    end else begin
      force_q <= force_err_i;
      tx_q    <= tx_d;
      if (gen_en) state_q <= pat_w[6:0];
    end
  end

  assign tx_o = tx_q;

  // R3
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !invert_i) |=> tx_q == $past(user_i))
    else $error("passthrough word mismatch");

  // R4
  invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && invert_i) |=> tx_q == ~$past(user_i))
    else $error("inverted passthrough mismatch");
endmodule

// File: rtl/prbs7_rx_chk.sv
module prbs7_rx_chk
  import prbs_link_pkg::*;
#(
  parameter int W        = 16,
  parameter int CNT_W    = 16,
  parameter int LOCK_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       sel_i,
  input  logic [W-1:0]     data_i,
  output logic             err_o,
  output logic             locked_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [6:0]       seed_q, seed_d;
  logic [2:0]       sel_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             locked_q, locked_d, err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     exp_w;
  logic             active, clear, mism, cnt_full;

  prbs7_expand #(.W(W)) u_expand (.seed_i(seed_q), .word_o(exp_w));

  always_comb begin
    active   = (sel_i == PAT_PRBS7);
    clear    = (sel_i != sel_q);
    mism     = (data_i != exp_w);
    cnt_full = &cnt_q;
    seed_d   = data_i[6:0];
    run_d    = run_q;
    locked_d = locked_q;
    err_d    = 1'b0;
    cnt_d    = cnt_q;
    if (clear) cnt_d = '0;
    if (!active || clear) begin
      run_d    = '0;
      locked_d = 1'b0;
    end else if (locked_q) begin
      seed_d = exp_w[6:0];
      err_d  = mism;
      if (mism && !cnt_full) cnt_d = cnt_q + CNT_W'(1);
    end else if (mism) begin
      run_d = '0;
    end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
      run_d    = '0;
      locked_d = 1'b1;
    end else begin
      run_d = run_q + RUN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q   <= LFSR_SEED;
      sel_q    <= PAT_OFF;
      run_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      seed_q   <= seed_d;
      sel_q    <= sel_i;
      run_q    <= run_d;
      locked_q <= locked_d;
      err_q    <= err_d;
      cnt_q    <= cnt_d;
    end
  end

  assign err_o    = err_q;
  assign locked_o = locked_q;
  assign cnt_o    = cnt_q;

  // R6
  lock_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(run_q) == RUN_W'(LOCK_RUN - 1))
    else $error("lock without full run");

  // R7
  err_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> locked_q)
    else $error("error flag while unlocked");

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_full && !clear) |=> &cnt_q)
    else $error("counter wrapped");

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1) || cnt_q == '0))
    else $error("counter jumped");

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!err_q && !locked_q))
    else $error("checker active while off");
endmodule

// File: rtl/prbs_link_test.sv
module prbs_link_test
  import prbs_link_pkg::*;
#(
  parameter int W        = 16,
  parameter int CNT_W    = 16,
  parameter int LOCK_RUN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       pat_tx_sel,
  input  logic             tx_force_err,
  input  logic             tx_invert,
  input  logic [W-1:0]     tx_user,
  output logic [W-1:0]     tx_data,
  input  logic [2:0]       pat_rx_sel,
  input  logic [W-1:0]     rx_data,
  input  logic             err_loop_en,
  output logic             rx_err,
  output logic             rx_locked,
  output logic [CNT_W-1:0] rx_err_cnt
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  prbs7_tx_gen #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .sel_i(pat_tx_sel),
    .force_err_i(tx_force_err), .loop_en_i(err_loop_en), .rx_err_i(rx_err),
    .invert_i(tx_invert), .user_i(tx_user), .tx_o(tx_data)
  );

  prbs7_rx_chk #(.W(W), .CNT_W(CNT_W), .LOCK_RUN(LOCK_RUN)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .sel_i(pat_rx_sel), .data_i(rx_data),
    .err_o(rx_err), .locked_o(rx_locked), .cnt_o(rx_err_cnt)
  );
endmodule

// File: tb/test_prbs_link_test.sv
`timescale 1ns/1ps
module test_prbs_link_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic [2:0]   pat_tx_sel = 3'b000;
  logic         tx_force_err = 1'b0;
  logic         tx_invert = 1'b0;
  logic [W-1:0] tx_user = '0;
  logic [W-1:0] tx_data;
  logic [2:0]   pat_rx_sel = 3'b000;
  logic [W-1:0] rx_data = '0;
  logic         err_loop_en = 1'b0;
  logic         rx_err, rx_locked;
  logic [15:0]  rx_err_cnt;

  prbs_link_test i_prbs_link_test (
    .clk(clk), .rst_n(rst_n), .pat_tx_sel(pat_tx_sel), .tx_force_err(tx_force_err),
    .tx_invert(tx_invert), .tx_user(tx_user), .tx_data(tx_data),
    .pat_rx_sel(pat_rx_sel), .rx_data(rx_data), .err_loop_en(err_loop_en),
    .rx_err(rx_err), .rx_locked(rx_locked), .rx_err_cnt(rx_err_cnt)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, skip = 0;
  bit done = 0;

  // reference model state
  logic [6:0]   m_gen = 7'h7F, m_seed = 7'h7F, src = 7'h2A;
  logic         m_fe = 0, m_err = 0, m_locked = 0;
  logic [2:0]   m_sel_prev = 3'b000;
  logic [W-1:0] m_tx = '0;
  int           m_run = 0, m_cnt = 0;

  function automatic logic [W-1:0] p7_word(input logic [6:0] st);
    bit h[$];
    logic [W-1:0] w;
    for (int k = 6; k >= 0; k--) h.push_back(st[k]);
    for (int k = 0; k < W; k++) begin
      bit nb;
      nb = h[h.size() - 7] ^ h[h.size() - 6];
      h.push_back(nb);
      w[W - 1 - k] = nb;
    end
    return w;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(req, "tx_data", 32'(tx_data), 32'(m_tx));
    check(req, "rx_err", 32'(rx_err), 32'(m_err));
    check(req, "rx_locked", 32'(rx_locked), 32'(m_locked));
    check(req, "rx_err_cnt", 32'(rx_err_cnt), 32'(m_cnt));
  endtask

  task automatic model_edge();
    logic inj, fl, clr, bad;
    logic [W-1:0] w, e;
    inj  = tx_force_err & ~m_fe;
    m_fe = tx_force_err;
    if (pat_tx_sel == 3'b001) begin
      w = p7_word(m_gen);
      m_gen = w[6:0];
      fl = err_loop_en ? m_err : inj;
      w[0] = w[0] ^ fl;
    end else w = tx_user;
    if (tx_invert) w = ~w;
    m_tx = w;
    clr = (pat_rx_sel != m_sel_prev);
    m_sel_prev = pat_rx_sel;
    if (clr) m_cnt = 0;
    if (clr || pat_rx_sel != 3'b001) begin
      m_run = 0; m_locked = 0; m_err = 0;
    end else begin
      e = p7_word(m_seed);
      bad = (rx_data != e);
      if (m_locked) begin
        m_seed = e[6:0];
        m_err = bad;
        if (bad && m_cnt < 65535) m_cnt++;
      end else begin
        m_seed = rx_data[6:0];
        m_err = 0;
        if (bad) m_run = 0;
        else begin
          m_run++;
          if (m_run == 8) begin m_locked = 1; m_run = 0; end
        end
      end
    end
    if (clr || pat_rx_sel != 3'b001) m_seed = rx_data[6:0];
  endtask

  task automatic cycle(string req);
    @(posedge clk);
    if (skip > 0) skip--;
    else model_edge();
    @(negedge clk);
    compare(req);
  endtask

  task automatic drive_rx(logic [W-1:0] mask);
    logic [W-1:0] w;
    w = p7_word(src);
    src = w[6:0];
    rx_data = w ^ mask;
  endtask

  initial begin
    #950000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    skip = 2;
    cycle("R1"); cycle("R1");
    // passthrough, then inverted
    for (int i = 0; i < 6; i++) begin tx_user = W'($urandom); cycle("R3"); end
    tx_invert = 1'b1;
    for (int i = 0; i < 6; i++) begin tx_user = W'($urandom); cycle("R4"); end
    tx_invert = 1'b0;
    // pattern on both sides, clean stream
    pat_tx_sel = 3'b001; pat_rx_sel = 3'b001;
    for (int i = 0; i < 14; i++) begin drive_rx('0); cycle("R2"); end
    check("R6", "locked after clean run", 32'(rx_locked), 32'd1);
    tx_invert = 1'b1;
    for (int i = 0; i < 4; i++) begin drive_rx('0); cycle("R4"); end
    tx_invert = 1'b0;
    // held force error
    tx_force_err = 1'b1;
    for (int i = 0; i < 6; i++) begin drive_rx('0); cycle("R5"); end
    tx_force_err = 1'b0;
    for (int i = 0; i < 3; i++) begin drive_rx('0); cycle("R5"); end
    // spaced single-word errors
    for (int n = 0; n < 3; n++) begin
      drive_rx(16'h0001); cycle("R7");
      for (int i = 0; i < 4; i++) begin drive_rx('0); cycle("R7"); end
    end
    check("R8", "count after three errors", 32'(rx_err_cnt), 32'd3);
    // error loopback with force held
    err_loop_en = 1'b1; tx_force_err = 1'b1;
    for (int n = 0; n < 3; n++) begin
      drive_rx(16'h0400); cycle("R10");
      for (int i = 0; i < 3; i++) begin drive_rx('0); cycle("R10"); end
    end
    err_loop_en = 1'b0; tx_force_err = 1'b0;
    // saturation
    for (int i = 0; i < 65560; i++) begin drive_rx(16'h0100); cycle("R8"); end
    check("R8", "saturated count", 32'(rx_err_cnt), 32'hFFFF);
    // select change clears, then idle
    pat_rx_sel = 3'b000;
    drive_rx(16'h0100); cycle("R9");
    check("R9", "count cleared", 32'(rx_err_cnt), 32'd0);
    for (int i = 0; i < 8; i++) begin rx_data = W'($urandom); cycle("R11"); end
    check("R11", "idle lock", 32'(rx_locked), 32'd0);
    pat_rx_sel = 3'b001;
    for (int i = 0; i < 12; i++) begin drive_rx('0); cycle("R6"); end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule